// File: doc/BRIEF.md
# Indirect PHY Register Access Engine

This block gives a host a four-byte register window for reaching the registers of one attached PHY over a two-wire serial management bus. The host loads a target word, which holds a PHY address and a register number. For a write it also loads a 16-bit value split across a low and a high data byte. It then writes a command byte that carries a select bit together with exactly one of a write-start or a read-start bit.

The engine clocks out one complete management frame and holds a busy bit at 1 while the frame runs. The host polls that bit. When a read finishes, the returned 16 bits are placed in the same two data bytes.

After busy clears, the host ends the command by writing the command byte with only the select bit set. It then leaves at least 5 µs before the next access. Requests are taken only through the window. No transfer waits on the far side, so the window has no back-pressure. The busy bit is the only flow control, and while it is set the window ignores host writes.

Top module: `phy_win_engine`

## Requirements
- R1: After reset, all four window bytes read 0x00, `mdc` is low and `mdio_oe` is low.
- R2: The target byte (window offset 0) keeps the PHY address in bits 7:6 and the register number in bits 4:0. Bit 5 always reads 0. The frame carries the PHY address zero-extended to 5 bits.
- R3: In the command byte (offset 3), bit 3 is select, bit 2 is read-start, bit 1 is write-start and bit 0 is busy, which is read-only. A frame starts only when select is 1 and exactly one start bit is 1. Any other command write leaves busy at 0 and produces no `mdc` activity.
- R4: Busy reads 1 from the cycle after an accepted command write until the frame is done. It then returns to 0, with `mdc` low. A frame lasts 64·CLK_DIV clocks, plus at most a few cycles of handoff.
- R5: A write frame, MSB first, is: 32 ones, start 01, opcode 01, PHY address (5 bits), register number (5 bits), turnaround 10, and then the data {high byte, low byte}.
- R6: A read frame uses opcode 10. `mdio_oe` is 0 during the two turnaround bits and the 16 data bits. `mdio_in` is sampled on the rising edges of `mdc`. When busy clears, the high data byte (offset 2) and the low data byte (offset 1) hold the received word.
- R7: `mdc` has a period of CLK_DIV system clocks with equal high and low halves. `mdc` and `mdio_oe` stay low whenever busy is 0.
- R8: While busy is 1, host writes to any window byte are ignored, including a new start command.
- R9: A command write with select only, and no start bit, leaves busy at 0. It produces no frame and does not change the data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe for the window byte at host_addr |
| host_addr | input | 2 | Window offset: 0 target, 1 data low, 2 data high, 3 command |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read-back of the window byte at host_addr |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data driven by the engine |
| mdio_oe | output | 1 | Drive enable for mdio_out |
| mdio_in | input | 1 | Management data from the PHY |

## Verification
The assertions assume the host uses only the four window offsets. They also assume that `mdio_in` settles before each rising edge of `mdc`. The bench's PHY model meets this by changing `mdio_in` only on falling edges of `mdc`. The bench always polls busy before it ends a command. On purpose, it also writes to every window byte while busy is 1. This shows through read-back, and through the stream of frames the PHY model collects, that such writes have no effect.

// File: rtl/phy_win_pkg.sv
package phy_win_pkg;
  localparam int MDIO_ADDR_W = 5;
  localparam int MDIO_DATA_W = 16;

  // command byte bit positions
  localparam int CMD_BUSY = 0;
  localparam int CMD_WR   = 1;
  localparam int CMD_RD   = 2;
  localparam int CMD_SEL  = 3;

  typedef enum logic [1:0] {
    WIN_TGT = 2'd0,
    WIN_DLO = 2'd1,
    WIN_DHI = 2'd2,
    WIN_CMD = 2'd3
  } win_off_e;

  typedef struct packed {
    logic sel;
    logic rd;
    logic wr;
  } cmd_bits_t;

  typedef struct packed {
    logic                   is_read;
    logic [MDIO_ADDR_W-1:0] phy;
    logic [MDIO_ADDR_W-1:0] regno;
    logic [MDIO_DATA_W-1:0] wdata;
  } mgmt_req_t;
endpackage

// File: rtl/phy_win_regs.sv
module phy_win_regs
  import phy_win_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int PHY_FLD_W = 2,
  parameter int REG_FLD_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_we,
  input  logic [1:0]            host_addr,
  input  logic [BYTE_W-1:0]     host_wdata,
  input  logic                  busy,
  input  logic                  rd_load,
  input  logic [2*BYTE_W-1:0]   rd_word,
  output logic [BYTE_W-1:0]     host_rdata,
  output logic [PHY_FLD_W-1:0]  phy_fld,
  output logic [REG_FLD_W-1:0]  reg_fld,
  output logic [2*BYTE_W-1:0]   data_word,
  output logic                  cmd_acc,
  output cmd_bits_t             cmd_bits
);
  localparam int GAP_W = BYTE_W - PHY_FLD_W - REG_FLD_W;

  logic [BYTE_W-1:0] dlo_q, dhi_q;
  cmd_bits_t         cmd_q;
  logic              wr_ok;

  assign wr_ok   = host_we && !busy;
  assign cmd_acc = wr_ok && (host_addr == WIN_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_fld <= '0;
      reg_fld <= '0;
      dlo_q   <= '0;
      dhi_q   <= '0;
      cmd_q   <= '0;
    end else if (rd_load) begin
      dlo_q <= rd_word[BYTE_W-1:0];
      dhi_q <= rd_word[2*BYTE_W-1:BYTE_W];
    end else if (wr_ok) begin
      case (host_addr)
        WIN_TGT: begin
          phy_fld <= host_wdata[BYTE_W-1 -: PHY_FLD_W];
          reg_fld <= host_wdata[REG_FLD_W-1:0];
        end
        WIN_DLO: dlo_q <= host_wdata;
        WIN_DHI: dhi_q <= host_wdata;
        default: begin
          cmd_q.sel <= host_wdata[CMD_SEL];
          cmd_q.rd  <= host_wdata[CMD_RD];
          cmd_q.wr  <= host_wdata[CMD_WR];
        end
      endcase
    end
  end

  assign cmd_bits  = '{sel: host_wdata[CMD_SEL], rd: host_wdata[CMD_RD], wr: host_wdata[CMD_WR]};
  assign data_word = {dhi_q, dlo_q};

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      WIN_TGT: host_rdata = {phy_fld, {GAP_W{1'b0}}, reg_fld};
      WIN_DLO: host_rdata = dlo_q;
      WIN_DHI: host_rdata = dhi_q;
      default: begin
        host_rdata[CMD_BUSY] = busy;
        host_rdata[CMD_WR]   = cmd_q.wr;
        host_rdata[CMD_RD]   = cmd_q.rd;
        host_rdata[CMD_SEL]  = cmd_q.sel;
      end
    endcase
  end
endmodule

// File: rtl/phy_win_seq.sv
module phy_win_seq
  import phy_win_pkg::*;
#(
  parameter int PHY_FLD_W = 2,
  parameter int REG_FLD_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_acc,
  input  cmd_bits_t              cmd_bits,
  input  logic [PHY_FLD_W-1:0]   phy_fld,
  input  logic [REG_FLD_W-1:0]   reg_fld,
  input  logic [MDIO_DATA_W-1:0] data_word,
  input  logic                   frame_done,
  output logic                   busy,
  output logic                   start,
  output mgmt_req_t              req,
  output logic                   rd_load
);
  typedef enum logic {SQ_IDLE, SQ_RUN} sq_state_e;
  sq_state_e state;
  logic      go;

  assign go = cmd_acc && cmd_bits.sel && (cmd_bits.rd ^ cmd_bits.wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      start <= 1'b0;
      req   <= '0;
    end else begin
      start <= 1'b0;
      case (state)
        SQ_IDLE: if (go) begin
          state       <= SQ_RUN;
          start       <= 1'b1;
          req.is_read <= cmd_bits.rd;
          req.phy     <= MDIO_ADDR_W'(phy_fld);
          req.regno   <= MDIO_ADDR_W'(reg_fld);
          req.wdata   <= data_word;
        end
        default: if (frame_done) state <= SQ_IDLE;
      endcase
    end
  end

  assign busy    = (state == SQ_RUN);
  assign rd_load = busy && frame_done && req.is_read;
endmodule

// File: rtl/phy_win_mdio.sv
module phy_win_mdio
  import phy_win_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int PRE_LEN = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  mgmt_req_t              req,
  input  logic                   mdio_in,
  output logic                   mdc,
  output logic                   mdio_out,
  output logic                   mdio_oe,
  output logic                   done,
  output logic [MDIO_DATA_W-1:0] rd_data
);
  localparam int HALF     = CLK_DIV / 2;
  localparam int CNT_W    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int FRAME    = PRE_LEN + 4 + 2*MDIO_ADDR_W + 2 + MDIO_DATA_W;
  localparam int IDX_W    = $clog2(FRAME);
  localparam int TA_IDX   = PRE_LEN + 4 + 2*MDIO_ADDR_W;
  localparam int DATA_IDX = TA_IDX + 2;

  logic             active, rd_q;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [FRAME-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      rd_q    <= 1'b0;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      mdc     <= 1'b0;
      done    <= 1'b0;
      rd_data <= '0;
    end else if (!active) begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        rd_q   <= req.is_read;
        cnt    <= '0;
        idx    <= '0;
        shreg  <= {{PRE_LEN{1'b1}}, 2'b01,
                   req.is_read ? 2'b10 : 2'b01,
                   req.phy, req.regno,
                   req.is_read ? 2'b11 : 2'b10,
                   req.is_read ? {MDIO_DATA_W{1'b1}} : req.wdata};
      end
    end else begin
      if (cnt == CNT_W'(HALF-1)) begin
        mdc <= 1'b1;
        if (rd_q && idx >= IDX_W'(DATA_IDX))
          rd_data <= {rd_data[MDIO_DATA_W-2:0], mdio_in};
      end
      if (cnt == CNT_W'(CLK_DIV-1)) begin
        cnt <= '0;
        mdc <= 1'b0;
        if (idx == IDX_W'(FRAME-1)) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          idx   <= idx + 1'b1;
          shreg <= {shreg[FRAME-2:0], 1'b1};
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign mdio_out = shreg[FRAME-1];
  assign mdio_oe  = active && !(rd_q && idx >= IDX_W'(TA_IDX));
endmodule

// File: rtl/phy_win_engine.sv
module phy_win_engine
  import phy_win_pkg::*;
#(
  parameter int CLK_DIV   = 4,
  parameter int PRE_LEN   = 32,
  parameter int PHY_FLD_W = 2,
  parameter int REG_FLD_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic [1:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       mdc,
  output logic       mdio_out,
  output logic       mdio_oe,
  input  logic       mdio_in
);
  localparam int BYTE_W = MDIO_DATA_W / 2;

  logic                   busy_w, start_w, done_w, rd_load_w, cmd_acc_w;
  cmd_bits_t              cmd_bits_w;
  logic [PHY_FLD_W-1:0]   phy_fld_w;
  logic [REG_FLD_W-1:0]   reg_fld_w;
  logic [MDIO_DATA_W-1:0] data_word_w, rd_data_w;
  mgmt_req_t              req_w;

  phy_win_regs #(.BYTE_W(BYTE_W), .PHY_FLD_W(PHY_FLD_W), .REG_FLD_W(REG_FLD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .busy(busy_w), .rd_load(rd_load_w), .rd_word(rd_data_w),
    .host_rdata(host_rdata), .phy_fld(phy_fld_w), .reg_fld(reg_fld_w),
    .data_word(data_word_w), .cmd_acc(cmd_acc_w), .cmd_bits(cmd_bits_w)
  );

  phy_win_seq #(.PHY_FLD_W(PHY_FLD_W), .REG_FLD_W(REG_FLD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_acc(cmd_acc_w), .cmd_bits(cmd_bits_w),
    .phy_fld(phy_fld_w), .reg_fld(reg_fld_w), .data_word(data_word_w),
    .frame_done(done_w), .busy(busy_w), .start(start_w), .req(req_w), .rd_load(rd_load_w)
  );

  phy_win_mdio #(.CLK_DIV(CLK_DIV), .PRE_LEN(PRE_LEN)) u_mdio (
    .clk(clk), .rst_n(rst_n), .start(start_w), .req(req_w), .mdio_in(mdio_in),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .done(done_w), .rd_data(rd_data_w)
  );
endmodule

// File: rtl/phy_win_checker.sv
module phy_win_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       host_we,
  input logic [1:0] host_addr,
  input logic [3:1] cmd_wbits,
  input logic       mdc,
  input logic       mdio_oe,
  input logic       busy,
  input logic [6:0] tgt
);
  logic good_cmd, cmd_wr;
  assign cmd_wr   = host_we && (host_addr == 2'd3);
  assign good_cmd = cmd_wbits[3] && (cmd_wbits[2] ^ cmd_wbits[1]);

  a_r4_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_wr && good_cmd) |=> busy);

  a_r3_no_start_bad_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_wr && !good_cmd) |=> !busy);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  a_r8_target_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we && host_addr == 2'd0) |=> $stable(tgt));

  a_r4_end_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !mdc);
endmodule

bind phy_win_engine phy_win_checker i_phy_win_checker (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
  .cmd_wbits(host_wdata[3:1]), .mdc(mdc), .mdio_oe(mdio_oe), .busy(busy_w),
  .tgt({phy_fld_w, reg_fld_w})
);

// File: tb/test_phy_win_engine.sv
`timescale 1ns/1ps
module test_phy_win_engine;
  localparam int CLK_DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'd0, host_rdata;
  logic mdc, mdio_out, mdio_oe;
  logic mdio_in = 1'b1;

  int n_checks = 0, n_fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  phy_win_engine #(.CLK_DIV(CLK_DIV)) i_phy_win_engine (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---------------- scoreboard + PHY model ----------------
  typedef struct {
    bit         rd;
    logic [4:0] phy;
    logic [4:0] regno;
    logic [15:0] data;
  } frm_t;
  frm_t exp_q[$];

  logic [15:0] phy_regs [32];
  logic [63:0] cap;
  logic [15:0] drive_val;
  int pcnt, frames, rst_left;
  bit cur_rd, oe_bad;

  always @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      pcnt = 0; frames = 0; cur_rd = 0; oe_bad = 0; rst_left = 0; cap = '0;
      drive_val = '0;
      for (int i = 0; i < 32; i++) phy_regs[i] = 16'h0;
    end else begin
      cap = {cap[62:0], (cur_rd && pcnt >= 46) ? mdio_in : mdio_out};
      if (mdio_oe != !(cur_rd && pcnt >= 46)) oe_bad = 1;
      if (pcnt == 45) begin
        cur_rd = (cap[11:10] == 2'b10);
        if (cur_rd) begin
          if (cap[4:0] == 5'd0 && rst_left > 0) begin
            drive_val = phy_regs[0] | 16'h8000;
            rst_left--;
          end else begin
            if (cap[4:0] == 5'd0) phy_regs[0] = phy_regs[0] & 16'h7FFF;
            drive_val = phy_regs[cap[4:0]];
          end
        end
      end
      if (pcnt == 63) begin
        frm_t e;
        frames++;
        if (exp_q.size() == 0) begin
          chk(0, "R5 unexpected frame", 0, 1);
        end else begin
          e = exp_q.pop_front();
          chk(cap[63:32] == 32'hFFFFFFFF && cap[31:30] == 2'b01, "R5 preamble/start",
              int'(cap[63:30]), 32'hFFFFFFFF);
          chk(cap[29:28] == (e.rd ? 2'b10 : 2'b01), e.rd ? "R6 read opcode" : "R5 write opcode",
              int'(cap[29:28]), e.rd ? 2 : 1);
          chk(cap[27:23] == e.phy && cap[22:18] == e.regno, "R2 frame phy/reg",
              int'(cap[27:18]), int'({e.phy, e.regno}));
          chk(oe_bad == 0, "R6 drive enable per bit", int'(oe_bad), 0);
          if (!e.rd) begin
            chk(cap[17:0] == {2'b10, e.data}, "R5 turnaround+data", int'(cap[17:0]),
                int'({2'b10, e.data}));
            phy_regs[cap[22:18]] = cap[15:0];
            if (cap[22:18] == 5'd0 && cap[15]) rst_left = 2;
          end
        end
        pcnt = 0; cur_rd = 0; oe_bad = 0;
      end else begin
        pcnt++;
      end
    end
  end

  always @(negedge mdc or negedge rst_n) begin
    if (!rst_n) mdio_in = 1'b1;
    else if (cur_rd && pcnt == 47) mdio_in = 1'b0;
    else if (cur_rd && pcnt >= 48 && pcnt <= 63) mdio_in = drive_val[15-(pcnt-48)];
    else mdio_in = 1'b1;
  end

  // ---------------- host driver ----------------
  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    logic [7:0] c;
    cyc = 0;
    for (int n = 0; n < 5000; n++) begin
      host_read(2'd3, c);
      cyc++;
      if (!c[0]) return;
    end
    chk(0, "R4 busy never cleared", 1, 0);
  endtask

  task automatic phy_write(input logic [7:0] tgt, input logic [15:0] v);
    frm_t e;
    int cyc;
    host_write(2'd0, tgt);
    host_write(2'd1, v[7:0]);
    host_write(2'd2, v[15:8]);
    e.rd = 0; e.phy = {3'b0, tgt[7:6]}; e.regno = tgt[4:0]; e.data = v;
    exp_q.push_back(e);
    host_write(2'd3, 8'h0A);
    wait_idle(cyc);
    host_write(2'd3, 8'h08);
  endtask

  task automatic phy_read(input logic [7:0] tgt, input logic [15:0] expv, input string req);
    frm_t e;
    int cyc;
    logic [7:0] lo, hi;
    host_write(2'd0, tgt);
    e.rd = 1; e.phy = {3'b0, tgt[7:6]}; e.regno = tgt[4:0]; e.data = '0;
    exp_q.push_back(e);
    host_write(2'd3, 8'h0C);
    wait_idle(cyc);
    host_write(2'd3, 8'h08);
    host_read(2'd2, hi);
    host_read(2'd1, lo);
    chk({hi, lo} == expv, req, int'({hi, lo}), int'(expv));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int cyc, f0;
    realtime t1, t2, t3;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      host_read(2'(a), d);
      chk(d == 8'h00, "R1 window reset value", int'(d), 0);
    end
    chk(mdc == 0 && mdio_oe == 0, "R1 bus idle after reset", int'({mdc, mdio_oe}), 0);

    // R2 target byte layout
    host_write(2'd0, 8'hFF);
    host_read(2'd0, d);
    chk(d == 8'hDF, "R2 target read-back", int'(d), 8'hDF);

    // R5 write frame, R4 busy, R7 mdc timing
    host_write(2'd0, 8'h45);
    host_write(2'd1, 8'h34);
    host_write(2'd2, 8'h12);
    begin
      frm_t e;
      e.rd = 0; e.phy = 5'd1; e.regno = 5'd5; e.data = 16'h1234;
      exp_q.push_back(e);
    end
    host_write(2'd3, 8'h0A);
    host_read(2'd3, d);
    chk(d == 8'h0B, "R4 busy set after start", int'(d), 8'h0B);
    @(posedge mdc); t1 = $realtime;
    @(posedge mdc); t2 = $realtime;
    @(negedge mdc); t3 = $realtime;
    chk((t2 - t1) == 8.0 * CLK_DIV, "R7 mdc period", int'(t2 - t1), 8 * CLK_DIV);
    chk((t3 - t2) == 4.0 * CLK_DIV, "R7 mdc high time", int'(t3 - t2), 4 * CLK_DIV);
    wait_idle(cyc);
    cyc = cyc + 3 + 2 * CLK_DIV;   // cycles already spent before polling
    chk(cyc >= 64 * CLK_DIV && cyc <= 64 * CLK_DIV + 12, "R4 busy duration", cyc, 64 * CLK_DIV);
    chk(mdc == 0 && mdio_oe == 0, "R7 bus quiet when idle", int'({mdc, mdio_oe}), 0);

    // R9 end command
    f0 = frames;
    host_write(2'd3, 8'h08);
    host_read(2'd3, d);
    chk(d == 8'h08, "R9 select-only leaves busy low", int'(d), 8'h08);
    repeat (40) @(negedge clk);
    chk(frames == f0, "R9 no frame from select-only", frames, f0);
    host_read(2'd2, d);
    chk(d == 8'h12, "R9 data bytes kept", int'(d), 8'h12);

    // R6 read back
    host_write(2'd1, 8'h00);
    host_write(2'd2, 8'h00);
    phy_read(8'h45, 16'h1234, "R6 read data reg5");

    // second pattern: phy 3, reg 31
    phy_write(8'hDF, 16'hA5C3);
    phy_read(8'hDF, 16'hA5C3, "R6 read data phy3 reg31");

    // R8 writes during busy ignored
    host_write(2'd0, 8'h47);
    host_write(2'd1, 8'hEF);
    host_write(2'd2, 8'hBE);
    begin
      frm_t e;
      e.rd = 0; e.phy = 5'd1; e.regno = 5'd7; e.data = 16'hBEEF;
      exp_q.push_back(e);
    end
    f0 = frames;
    host_write(2'd3, 8'h0A);
    host_write(2'd0, 8'h4A);
    host_write(2'd1, 8'h00);
    host_write(2'd3, 8'h0C);
    wait_idle(cyc);
    host_read(2'd0, d);
    chk(d == 8'h47, "R8 target unchanged", int'(d), 8'h47);
    host_read(2'd1, d);
    chk(d == 8'hEF, "R8 data low unchanged", int'(d), 8'hEF);
    host_read(2'd3, d);
    chk(d == 8'h0A, "R8 command unchanged", int'(d), 8'h0A);
    repeat (40) @(negedge clk);
    chk(frames == f0 + 1, "R8 restart ignored", frames, f0 + 1);
    host_write(2'd3, 8'h08);
    phy_read(8'h47, 16'hBEEF, "R8 written value intact");

    // R3 malformed commands
    f0 = frames;
    host_write(2'd3, 8'h0E);
    host_read(2'd3, d);
    chk(d[0] == 0, "R3 both starts no busy", int'(d), 8'h0E);
    host_write(2'd3, 8'h02);
    host_read(2'd3, d);
    chk(d[0] == 0, "R3 write-start without select", int'(d), 8'h02);
    host_write(2'd3, 8'h04);
    repeat (50) @(negedge clk);
    chk(frames == f0 && mdc == 0, "R3 no frame from bad commands", frames, f0);

    // PHY reset bit through the window (R5 write, R6 read)
    host_write(2'd3, 8'h08);
    phy_write(8'h40, 16'h8000);
    phy_read(8'h40, 16'h8000, "R6 reset bit pending 1");
    phy_read(8'h40, 16'h8000, "R6 reset bit pending 2");
    phy_read(8'h40, 16'h0000, "R6 reset bit cleared");

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all frames seen", exp_q.size(), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule